// File: doc/BRIEF.md
# Revocation Bitmap with Capability Load Filter

This block keeps one revocation bit for every 32-bit word of a heap region and uses it to vet capability loads. The memory allocator sets a bit when it frees a word and clears it again once a full sweep of memory has removed every stale pointer to that word. Software reaches the bitmap through a simple 32-bit register bus mapped at a fixed window. Each register in the window holds 32 revocation bits.

The second interface is a check port that the load path drives with the base address and the tag bit of a capability being loaded. One cycle later the block reports whether the word holding that base is revoked. It also returns the tag bit to deliver, which is forced low on a revoked word so that the load yields plain data. A base address outside the covered region always passes the check.

With the default parameters the bitmap has 1024 registers in a 4 KiB window at 0x3000_0000 and covers 128 KiB starting at 0x4000_0000.

Top module: `revmap_filter`

## Requirements
- R1: After reset every revocation bit reads as 0, and `bus_rvalid` and `chk_rsp_valid` are low.
- R2: A bus write to byte address WINDOW_BASE + 4*k updates register k. Byte lane b (`bus_wdata[8b+7:8b]`) is stored only when `bus_be[b]` is 1, and the other lanes keep their old contents.
- R3: A bus read of register k raises `bus_rvalid` in the next cycle, with `bus_rdata` holding the current contents of register k. `bus_rvalid` is low in every cycle that does not follow a read.
- R4: A bus access whose address lies outside [WINDOW_BASE, WINDOW_BASE + 4*NUM_REGS) changes no register, and a read at such an address returns 0.
- R5: A check base address A inside the region maps to bit index i = (A − REGION_BASE) >> 2, which is bit (i & 31) of register (i >> 5). The two low address bits do not affect the result.
- R6: When the mapped bit is 1, `chk_revoked` is 1 and `chk_tag_out` is 0 in the cycle after the check.
- R7: A check base outside [REGION_BASE, REGION_BASE + 128*NUM_REGS) gives `chk_revoked` = 0, and `chk_tag_out` equals the `chk_tag_in` that came with the check.
- R8: Clearing a bit through the bus makes later checks on that word pass, with the tag kept.
- R9: When a bus write and a check touch the same register in the same cycle, the check result uses the register value from before the write.
- R10: `chk_rsp_valid` is high exactly in the cycle after `chk_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| chk_valid | input | 1 | Check request from the load path |
| chk_base | input | 32 | Base address of the capability being loaded |
| chk_tag_in | input | 1 | Tag bit of the loaded capability |
| chk_rsp_valid | output | 1 | Check result valid |
| chk_revoked | output | 1 | Mapped word is revoked |
| chk_tag_out | output | 1 | Tag to deliver, cleared on a revoked word |

## Verification
The bench runs a small configuration of eight registers and checks every covered word, using byte addresses with non-zero low bits so that a decoder that keeps those bits lands on the wrong bit. It probes the first and last addresses just outside both the register window and the region. A design that wraps the offset, or that checks only the upper bound, would then alias those addresses onto real bits. Partial byte-enable writes catch a store that writes whole words. A write and a check aimed at the same register in the same cycle catch a design that forwards the new data into the check. Each bit is cleared and then checked again, which exposes a design whose revocation state never returns to 0.

// File: rtl/revmap_pkg.sv
package revmap_pkg;

  localparam int unsigned LANES       = 4;
  localparam int unsigned BITS_PER_REG = 32;
  localparam int unsigned BITPOS_W    = 5;

  // Word offset of a byte address from a base; wraps below the base.
  function automatic logic [29:0] word_offset(input logic [31:0] addr,
                                              input logic [31:0] base);
    return 30'((addr - base) >> 2);
  endfunction

  // Merge write data into an old word under byte enables.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_w;
    for (int b = 0; b < LANES; b++) begin
      if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/revmap_decode.sv
module revmap_decode #(
  parameter logic [31:0] BASE  = 32'h0,
  parameter int unsigned OUT_W = 10
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [OUT_W-1:0] idx
);

  logic [29:0] word_full;

  assign word_full = revmap_pkg::word_offset(addr, BASE);
  // In range when at or above the base and the offset fits OUT_W bits.
  assign hit = (addr >= BASE) && (word_full[29:OUT_W] == '0);
  assign idx = word_full[OUT_W-1:0];

endmodule

// File: rtl/revmap_store.sv
module revmap_store #(
  parameter int unsigned NUM_REGS = 1024,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [31:0]      rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [31:0]      rd_data_b
);

  logic [31:0] mem_q [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= revmap_pkg::lane_merge(mem_q[wr_idx], wr_data, wr_be);
    end
  end

  // Both read ports sample the array before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_a <= '0;
      rd_data_b <= '0;
    end else begin
      rd_data_a <= mem_q[rd_idx_a];
      rd_data_b <= mem_q[rd_idx_b];
    end
  end

endmodule

// File: rtl/revmap_filter.sv
module revmap_filter #(
  parameter logic [31:0] REGION_BASE = 32'h4000_0000,
  parameter logic [31:0] WINDOW_BASE = 32'h3000_0000,
  parameter int unsigned NUM_REGS    = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  input  logic        chk_valid,
  input  logic [31:0] chk_base,
  input  logic        chk_tag_in,
  output logic        chk_rsp_valid,
  output logic        chk_revoked,
  output logic        chk_tag_out
);

  localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);
  localparam int unsigned BIT_IDX_W = REG_IDX_W + revmap_pkg::BITPOS_W;

  // Named internal events, observed by the bound checker.
  logic                          bus_in_win;
  logic [REG_IDX_W-1:0]          bus_reg_idx;
  logic                          bus_wr_fire;
  logic                          bus_rd_fire;
  logic                          chk_in_region;
  logic [BIT_IDX_W-1:0]          chk_bit_idx;
  logic [REG_IDX_W-1:0]          chk_reg_idx;
  logic [revmap_pkg::BITPOS_W-1:0] chk_bit_pos;
  logic [31:0]                   rd_word;
  logic [31:0]                   ck_word;

  logic                          rd_pend_q;
  logic                          rd_win_q;
  logic                          ck_pend_q;
  logic                          ck_hit_q;
  logic [revmap_pkg::BITPOS_W-1:0] ck_pos_q;
  logic                          ck_tag_q;

  revmap_decode #(.BASE(WINDOW_BASE), .OUT_W(REG_IDX_W)) u_bus_dec (
    .addr (bus_addr),
    .hit  (bus_in_win),
    .idx  (bus_reg_idx)
  );

  revmap_decode #(.BASE(REGION_BASE), .OUT_W(BIT_IDX_W)) u_chk_dec (
    .addr (chk_base),
    .hit  (chk_in_region),
    .idx  (chk_bit_idx)
  );

  assign chk_reg_idx = chk_bit_idx[BIT_IDX_W-1:revmap_pkg::BITPOS_W];
  assign chk_bit_pos = chk_bit_idx[revmap_pkg::BITPOS_W-1:0];
  assign bus_wr_fire = bus_req && bus_we && bus_in_win;
  assign bus_rd_fire = bus_req && !bus_we;

  revmap_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr_fire),
    .wr_idx    (bus_reg_idx),
    .wr_be     (bus_be),
    .wr_data   (bus_wdata),
    .rd_idx_a  (bus_reg_idx),
    .rd_data_a (rd_word),
    .rd_idx_b  (chk_reg_idx),
    .rd_data_b (ck_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_win_q  <= 1'b0;
      ck_pend_q <= 1'b0;
      ck_hit_q  <= 1'b0;
      ck_pos_q  <= '0;
      ck_tag_q  <= 1'b0;
    end else begin
      rd_pend_q <= bus_rd_fire;
      rd_win_q  <= bus_rd_fire && bus_in_win;
      ck_pend_q <= chk_valid;
      ck_hit_q  <= chk_valid && chk_in_region;
      ck_pos_q  <= chk_bit_pos;
      ck_tag_q  <= chk_tag_in;
    end
  end

  assign bus_rvalid    = rd_pend_q;
  assign bus_rdata     = rd_win_q ? rd_word : '0;
  assign chk_rsp_valid = ck_pend_q;
  assign chk_revoked   = ck_hit_q && ck_word[ck_pos_q];
  assign chk_tag_out   = ck_tag_q && !chk_revoked;

endmodule

// File: rtl/revmap_filter_chk.sv
module revmap_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_in_win,
  input logic        bus_rvalid,
  input logic [31:0] bus_rdata,
  input logic        chk_valid,
  input logic        chk_in_region,
  input logic        chk_tag_in,
  input logic        chk_rsp_valid,
  input logic        chk_revoked,
  input logic        chk_tag_out
);

  assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |=> bus_rvalid);

  assert_no_rvalid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  assert_outside_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && !bus_in_win |=> bus_rdata == '0);

  assert_rsp_after_check_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_rsp_valid);

  assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_rsp_valid);

  assert_revoked_clears_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_revoked |-> chk_rsp_valid && !chk_tag_out);

  assert_outside_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !chk_in_region |=> !chk_revoked);

  assert_tag_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_rsp_valid && !chk_revoked |-> chk_tag_out == $past(chk_tag_in));

endmodule

bind revmap_filter revmap_filter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .bus_in_win    (bus_in_win),
  .bus_rvalid    (bus_rvalid),
  .bus_rdata     (bus_rdata),
  .chk_valid     (chk_valid),
  .chk_in_region (chk_in_region),
  .chk_tag_in    (chk_tag_in),
  .chk_rsp_valid (chk_rsp_valid),
  .chk_revoked   (chk_revoked),
  .chk_tag_out   (chk_tag_out)
);

// File: tb/test_revmap_filter.sv
module test_revmap_filter;

  localparam logic [31:0] RB   = 32'h4000_0000;
  localparam logic [31:0] WB   = 32'h3000_0000;
  localparam int NREG          = 8;
  localparam longint COVER     = longint'(NREG) * 128;
  localparam int WIN_BYTES     = NREG * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_base = '0;
  logic        chk_tag_in = 1'b0;
  logic        chk_rsp_valid, chk_revoked, chk_tag_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] model [NREG];

  always #10 clk = ~clk;

  revmap_filter #(.REGION_BASE(RB), .WINDOW_BASE(WB), .NUM_REGS(NREG)) i_revmap_filter (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .chk_valid(chk_valid), .chk_base(chk_base), .chk_tag_in(chk_tag_in),
    .chk_rsp_valid(chk_rsp_valid), .chk_revoked(chk_revoked), .chk_tag_out(chk_tag_out)
  );

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic logic in_win(input logic [31:0] a);
    return (longint'(a) >= longint'(WB)) && (longint'(a) < longint'(WB) + WIN_BYTES);
  endfunction

  function automatic logic exp_rev(input logic [31:0] a);
    longint off;
    longint wi;
    off = longint'(a) - longint'(RB);
    if (off < 0 || off >= COVER) return 1'b0;
    wi = off / 4;
    return model[int'(wi / 32)][int'(wi % 32)];
  endfunction

  task automatic bus_wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    if (in_win(a)) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) model[(a - WB) >> 2][8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic bus_rd(input logic [31:0] a, input logic [31:0] exp, input string req);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    expect_eq({req, " rvalid"}, 32'(bus_rvalid), 32'd1);
    expect_eq({req, " rdata"}, bus_rdata, exp);
    bus_req = 1'b0;
  endtask

  task automatic do_chk(input logic [31:0] a, input logic tag, input string req);
    logic er;
    er = exp_rev(a);
    chk_valid = 1'b1; chk_base = a; chk_tag_in = tag;
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq({req, " rsp_valid"}, 32'(chk_rsp_valid), 32'd1);
    expect_eq({req, " revoked"}, 32'(chk_revoked), 32'(er));
    expect_eq({req, " tag_out"}, 32'(chk_tag_out), 32'(tag & ~er));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] outside [7];
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    expect_eq("R1 rvalid idle", 32'(bus_rvalid), 32'd0);
    expect_eq("R1 rsp_valid idle", 32'(chk_rsp_valid), 32'd0);
    for (int r = 0; r < NREG; r++) bus_rd(WB + 32'(r * 4), 32'd0, "R1 reset contents");
    @(negedge clk);
    expect_eq("R3 rvalid low after idle", 32'(bus_rvalid), 32'd0);

    // R2/R3: full writes then partial byte-enable writes
    for (int r = 0; r < NREG; r++) bus_wr(WB + 32'(r * 4), 4'hF, 32'(r + 1) * 32'h9E37_79B9);
    for (int r = 0; r < NREG; r++) bus_rd(WB + 32'(r * 4), model[r], "R3 full write readback");
    for (int r = 0; r < NREG; r++)
      bus_wr(WB + 32'(r * 4), 4'(r * 5 + 3), ~(32'(r + 7) * 32'h0101_0F0F));
    bus_wr(WB + 32'(7 * 4), 4'hF, 32'hFFFF_FFFF);
    for (int r = 0; r < NREG; r++) bus_rd(WB + 32'(r * 4), model[r], "R2 byte enable merge");

    // R4: accesses outside the window
    bus_wr(WB - 32'd4, 4'hF, 32'hFFFF_FFFF);
    bus_wr(WB + 32'(WIN_BYTES), 4'hF, 32'hFFFF_FFFF);
    bus_rd(WB - 32'd4, 32'd0, "R4 read below window");
    bus_rd(WB + 32'(WIN_BYTES), 32'd0, "R4 read above window");
    for (int r = 0; r < NREG; r++) bus_rd(WB + 32'(r * 4), model[r], "R4 registers untouched");

    // R5/R6: every covered word, low address bits varied
    for (int w = 0; w < NREG * 32; w++)
      do_chk(RB + 32'(w * 4) + 32'(w % 4), 1'(w % 2 == 0), "R5 R6 word sweep");
    @(negedge clk);
    expect_eq("R10 rsp_valid low after idle", 32'(chk_rsp_valid), 32'd0);

    // R7: outside the region
    outside[0] = RB - 32'd4;  outside[1] = RB - 32'd1;
    outside[2] = RB + 32'(COVER); outside[3] = RB + 32'(COVER) + 32'd4;
    outside[4] = 32'd0;       outside[5] = 32'hFFFF_FFFC; outside[6] = WB;
    for (int i = 0; i < 7; i++) do_chk(outside[i], 1'b1, "R7 outside region");

    // R9: write and check on the same register in the same cycle
    bus_wr(WB + 32'd12, 4'hF, 32'h0000_0000);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = WB + 32'd12; bus_be = 4'hF;
    bus_wdata = 32'h0000_0020;
    chk_valid = 1'b1; chk_base = RB + 32'((3 * 32 + 5) * 4); chk_tag_in = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; chk_valid = 1'b0;
    expect_eq("R9 old value seen", 32'(chk_revoked), 32'd0);
    expect_eq("R9 tag kept", 32'(chk_tag_out), 32'd1);
    model[3] = 32'h0000_0020;
    do_chk(RB + 32'((3 * 32 + 5) * 4), 1'b1, "R9 new value next");

    // R8: clear one byte, then everything
    bus_wr(WB + 32'd28, 4'h1, 32'h0);
    for (int w = 7 * 32; w < 7 * 32 + 10; w++) do_chk(RB + 32'(w * 4), 1'b1, "R8 partial clear");
    for (int r = 0; r < NREG; r++) bus_wr(WB + 32'(r * 4), 4'hF, 32'h0);
    for (int w = 0; w < NREG * 32; w++) do_chk(RB + 32'(w * 4) + 32'd2, 1'b1, "R8 all cleared");

    finish_run();
  end

endmodule